// File: doc/BRIEF.md
# Speculative Reorder Buffer

This block keeps a circular queue of in-flight instructions so that they can finish out of order while the architectural state still changes strictly in program order. An instruction claims the slot at the tail when it issues, and the slot number goes back to the issue logic as the rename tag. Execution units later return a result with that tag. The result lands in the matching slot and the slot is marked ready, but no register or memory is written at that point.

While a completed result waits for retirement, any younger instruction can read it by presenting the tag on the lookup port. The oldest slot retires only once it is ready, and at most one slot retires per cycle. A register operation drives the register-file write port and a store drives the memory write port. A branch retires without writing anything. If that branch was reported as mispredicted, every younger slot is discarded as it retires. A separate flush input discards all slots at once, for example on an exception.

Top module: `spec_rob`

## Requirements
- R1: After reset, count is 0, empty is 1, full is 0 and issueReady is 1.
- R2: An accepted issue takes the slot at the tail and returns it on issueTag. Successive issues receive consecutive tags that wrap modulo DEPTH (8 by default). A valid slot is never re-allocated.
- R3: With DEPTH slots occupied, full is 1 and issueReady is 0. An issue attempted while full is ignored and count stays at DEPTH.
- R4: A completion (doneValid, doneTag, doneValue) stores the value in the tagged slot and marks it ready. A slot that is not at the head produces no commit output, even when it is ready.
- R5: lookupHit is 1 and lookupValue carries the stored result when the slot named by lookupTag is valid and completed. Otherwise lookupHit is 0.
- R6: When the head slot is ready and holds a register operation (kind code 0), commitRegEn is 1 in that same cycle, with commitRegIdx equal to the low REG_W bits of the destination and commitRegData equal to the value. The head advances at the next edge, and retirement follows program order.
- R7: A ready store at the head (kind code 1) drives commitMemEn with commitMemAddr equal to the destination and commitMemData equal to the value, and commitRegEn stays 0.
- R8: A ready branch at the head (kind code 2) retires with both write enables at 0. If it was completed with doneMispredict set, all younger slots are discarded: count becomes 0 and the next issue receives the tag after the branch.
- R9: flushIn discards every slot at the next edge and has priority over an issue or a commit in the same cycle. Afterwards count is 0 and the next issue receives the tag that was at the head.
- R10: At most one slot retires per cycle, so commitRegEn and commitMemEn are never both 1.
- R11: An issue and a retirement in the same cycle leave count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| issueValid | input | 1 | Request to allocate a slot |
| issueKind | input | 2 | 0 register op, 1 store, 2 branch |
| issueDest | input | DEST_W | Register number or memory address |
| issueReady | output | 1 | A slot can be allocated this cycle |
| issueTag | output | IDX_W | Slot given to the issuing instruction |
| doneValid | input | 1 | Completion strobe from an execution unit |
| doneTag | input | IDX_W | Slot being completed |
| doneValue | input | DATA_W | Result value |
| doneMispredict | input | 1 | Branch outcome differed from prediction |
| lookupTag | input | IDX_W | Slot whose result is requested |
| lookupHit | output | 1 | Requested slot holds a finished result |
| lookupValue | output | DATA_W | Finished result of the requested slot |
| commitRegEn | output | 1 | Register-file write strobe |
| commitRegIdx | output | REG_W | Register written |
| commitRegData | output | DATA_W | Register write value |
| commitMemEn | output | 1 | Memory write strobe |
| commitMemAddr | output | DEST_W | Memory address written |
| commitMemData | output | DATA_W | Memory write value |
| flushIn | input | 1 | Discard every slot |
| full | output | 1 | All slots occupied |
| empty | output | 1 | No slot occupied |
| count | output | IDX_W+1 | Number of occupied slots |

## Verification
The bench completes slots youngest-first, so a design that retired whatever finished first would show up in the scoreboard as a commit in the wrong order. It fills the queue across the tag wrap and then issues once more. A design with a wrong full test would overwrite the head or report a count of 9. A mispredicted branch is placed in front of two already finished younger slots, and a design that discarded too little would release their register and memory writes. Finally, a flush is driven in the same cycle as an issue, and an issue is driven in the same cycle as a retirement. Wrong priority there would leave a stale slot behind, or make the count drift.

// File: rtl/rob_pkg.sv
package rob_pkg;

  // Instruction kind codes held in each slot.
  localparam logic [1:0] KIND_REG    = 2'd0;
  localparam logic [1:0] KIND_STORE  = 2'd1;
  localparam logic [1:0] KIND_BRANCH = 2'd2;

  // Strobes from the control to the slot storage.
  typedef struct packed {
    logic alloc;     // write a new slot at the tail
    logic retire;    // release the head slot
    logic clearAll;  // drop every slot
  } robStrobe_t;

endpackage

// File: rtl/rob_ctrl.sv
module rob_ctrl
  import rob_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             issueValid,
  input  logic             flushIn,
  input  logic             headValid,
  input  logic             headReady,
  input  logic [1:0]       headKind,
  input  logic             headMis,
  output robStrobe_t       strobe,
  output logic [IDX_W-1:0] headIdx,
  output logic [IDX_W-1:0] tailIdx,
  output logic [CNT_W-1:0] count,
  output logic             issueReady,
  output logic             full,
  output logic             empty
);

  logic [IDX_W-1:0] headQ, tailQ;
  logic [CNT_W-1:0] countQ;
  logic             canRetire, mispFlush, doAlloc;
  logic [IDX_W-1:0] headNext;

  assign full      = (countQ == CNT_W'(DEPTH));
  assign empty     = (countQ == '0);
  assign canRetire = headValid && headReady && !flushIn;
  assign mispFlush = canRetire && (headKind == KIND_BRANCH) && headMis;
  assign issueReady = !full && !flushIn && !mispFlush;
  assign doAlloc   = issueValid && issueReady;
  assign headNext  = headQ + IDX_W'(1);

  always_comb begin
    strobe          = '0;
    strobe.alloc    = doAlloc;
    strobe.retire   = canRetire;
    strobe.clearAll = flushIn || mispFlush;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      headQ  <= '0;
      tailQ  <= '0;
      countQ <= '0;
    end else if (flushIn) begin
      tailQ  <= headQ;
      countQ <= '0;
    end else if (mispFlush) begin
      headQ  <= headNext;
      tailQ  <= headNext;
      countQ <= '0;
    end else begin
      if (canRetire) headQ <= headNext;
      if (doAlloc)   tailQ <= tailQ + IDX_W'(1);
      countQ <= countQ + CNT_W'(doAlloc) - CNT_W'(canRetire);
    end
  end

  assign headIdx = headQ;
  assign tailIdx = tailQ;
  assign count   = countQ;

  // R3: occupancy never exceeds the slot count
  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
    countQ <= CNT_W'(DEPTH));

  // R3: nothing is allocated while full
  assert_no_alloc_full_R3: assert property (@(posedge clk) disable iff (!rstN)
    full |-> !strobe.alloc);

  // R6: only a valid, completed head is released
  assert_retire_ready_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.retire |-> (headValid && headReady));

  // R6: an ordinary retirement moves the head by exactly one
  assert_head_step_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.retire && !strobe.clearAll) |=> (headQ == $past(headQ) + IDX_W'(1)));

  // R9: a flush leaves the queue empty
  assert_flush_empty_R9: assert property (@(posedge clk) disable iff (!rstN)
    flushIn |=> (countQ == '0 && tailQ == headQ));

  // R8: a mispredicted branch retirement leaves the queue empty
  assert_misp_empty_R8: assert property (@(posedge clk) disable iff (!rstN)
    (mispFlush && !flushIn) |=> (countQ == '0 && tailQ == headQ));

  // R11: issue and retirement together keep the count
  assert_count_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.alloc && strobe.retire && !strobe.clearAll) |=> $stable(countQ));

endmodule

// File: rtl/rob_store.sv
module rob_store
  import rob_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  parameter int DEST_W = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  robStrobe_t        strobe,
  input  logic [IDX_W-1:0]  allocIdx,
  input  logic [IDX_W-1:0]  headIdx,
  input  logic [1:0]        issueKind,
  input  logic [DEST_W-1:0] issueDest,
  input  logic              doneValid,
  input  logic [IDX_W-1:0]  doneTag,
  input  logic [DATA_W-1:0] doneValue,
  input  logic              doneMispredict,
  input  logic [IDX_W-1:0]  lookupTag,
  output logic              lookupHit,
  output logic [DATA_W-1:0] lookupValue,
  output logic              headValid,
  output logic              headReady,
  output logic [1:0]        headKind,
  output logic              headMis,
  output logic [DEST_W-1:0] headDest,
  output logic [DATA_W-1:0] headValue
);

  logic [DEPTH-1:0]  validQ, readyQ, misQ;
  logic [1:0]        kindQ  [DEPTH];
  logic [DEST_W-1:0] destQ  [DEPTH];
  logic [DATA_W-1:0] valueQ [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : gSlot
    logic allocHere, retireHere, doneHere;
    assign allocHere  = strobe.alloc  && (allocIdx == IDX_W'(i));
    assign retireHere = strobe.retire && (headIdx  == IDX_W'(i));
    assign doneHere   = doneValid && (doneTag == IDX_W'(i)) && validQ[i];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        validQ[i] <= 1'b0;
        readyQ[i] <= 1'b0;
        misQ[i]   <= 1'b0;
      end else if (strobe.clearAll) begin
        validQ[i] <= 1'b0;
        readyQ[i] <= 1'b0;
      end else if (allocHere) begin
        validQ[i] <= 1'b1;
        readyQ[i] <= 1'b0;
        misQ[i]   <= 1'b0;
      end else if (retireHere) begin
        validQ[i] <= 1'b0;
        readyQ[i] <= 1'b0;
      end else if (doneHere) begin
        readyQ[i] <= 1'b1;
        misQ[i]   <= doneMispredict;
      end
    end

    always_ff @(posedge clk) begin
      if (allocHere) begin
        kindQ[i] <= issueKind;
        destQ[i] <= issueDest;
      end
      if (doneHere) valueQ[i] <= doneValue;
    end
  end

  assign lookupHit   = validQ[lookupTag] && readyQ[lookupTag];
  assign lookupValue = valueQ[lookupTag];

  assign headValid = validQ[headIdx];
  assign headReady = readyQ[headIdx];
  assign headKind  = kindQ[headIdx];
  assign headMis   = misQ[headIdx];
  assign headDest  = destQ[headIdx];
  assign headValue = valueQ[headIdx];

  // R2: allocation never lands on an occupied slot
  assert_alloc_free_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.alloc |-> !validQ[allocIdx]);

  // R4: a completion to a live slot leaves it ready with the value
  assert_done_ready_R4: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid && validQ[doneTag] && !strobe.clearAll && !(strobe.retire && headIdx == doneTag))
      |=> (readyQ[$past(doneTag)] && valueQ[$past(doneTag)] == $past(doneValue)));

endmodule

// File: rtl/spec_rob.sv
module spec_rob
  import rob_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  parameter int DEST_W = 16,
  parameter int REG_W  = 5,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              issueValid,
  input  logic [1:0]        issueKind,
  input  logic [DEST_W-1:0] issueDest,
  output logic              issueReady,
  output logic [IDX_W-1:0]  issueTag,
  input  logic              doneValid,
  input  logic [IDX_W-1:0]  doneTag,
  input  logic [DATA_W-1:0] doneValue,
  input  logic              doneMispredict,
  input  logic [IDX_W-1:0]  lookupTag,
  output logic              lookupHit,
  output logic [DATA_W-1:0] lookupValue,
  output logic              commitRegEn,
  output logic [REG_W-1:0]  commitRegIdx,
  output logic [DATA_W-1:0] commitRegData,
  output logic              commitMemEn,
  output logic [DEST_W-1:0] commitMemAddr,
  output logic [DATA_W-1:0] commitMemData,
  input  logic              flushIn,
  output logic              full,
  output logic              empty,
  output logic [CNT_W-1:0]  count
);

  robStrobe_t        strobe;
  logic [IDX_W-1:0]  headIdx, tailIdx;
  logic              headValid, headReady, headMis;
  logic [1:0]        headKind;
  logic [DEST_W-1:0] headDest;
  logic [DATA_W-1:0] headValue;

  rob_ctrl #(.DEPTH(DEPTH)) uCtrl (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .flushIn(flushIn),
    .headValid(headValid), .headReady(headReady), .headKind(headKind),
    .headMis(headMis), .strobe(strobe), .headIdx(headIdx), .tailIdx(tailIdx),
    .count(count), .issueReady(issueReady), .full(full), .empty(empty)
  );

  rob_store #(.DEPTH(DEPTH), .DATA_W(DATA_W), .DEST_W(DEST_W)) uStore (
    .clk(clk), .rstN(rstN), .strobe(strobe), .allocIdx(tailIdx), .headIdx(headIdx),
    .issueKind(issueKind), .issueDest(issueDest), .doneValid(doneValid),
    .doneTag(doneTag), .doneValue(doneValue), .doneMispredict(doneMispredict),
    .lookupTag(lookupTag), .lookupHit(lookupHit), .lookupValue(lookupValue),
    .headValid(headValid), .headReady(headReady), .headKind(headKind),
    .headMis(headMis), .headDest(headDest), .headValue(headValue)
  );

  assign issueTag      = tailIdx;
  assign commitRegEn   = strobe.retire && (headKind == KIND_REG);
  assign commitRegIdx  = headDest[REG_W-1:0];
  assign commitRegData = headValue;
  assign commitMemEn   = strobe.retire && (headKind == KIND_STORE);
  assign commitMemAddr = headDest;
  assign commitMemData = headValue;

  // R10: one write port active at a time
  assert_single_commit_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(commitRegEn && commitMemEn));

  // R9: no architectural write during a flush
  assert_flush_no_commit_R9: assert property (@(posedge clk) disable iff (!rstN)
    flushIn |-> !(commitRegEn || commitMemEn));

endmodule

// File: tb/spec_rob_test.sv
module spec_rob_test;
  import rob_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH  = 8;
  localparam int DATA_W = 32;
  localparam int DEST_W = 16;
  localparam int REG_W  = 5;
  localparam int IDX_W  = 3;

  logic clk = 0, rstN = 0;
  logic issueValid = 0, doneValid = 0, doneMispredict = 0, flushIn = 0;
  logic [1:0] issueKind = '0;
  logic [DEST_W-1:0] issueDest = '0;
  logic [IDX_W-1:0] doneTag = '0, lookupTag = '0;
  logic [DATA_W-1:0] doneValue = '0;
  logic issueReady, lookupHit, commitRegEn, commitMemEn, full, empty;
  logic [IDX_W-1:0] issueTag;
  logic [DATA_W-1:0] lookupValue, commitRegData, commitMemData;
  logic [REG_W-1:0] commitRegIdx;
  logic [DEST_W-1:0] commitMemAddr;
  logic [IDX_W:0] count;

  spec_rob #(.DEPTH(DEPTH), .DATA_W(DATA_W), .DEST_W(DEST_W), .REG_W(REG_W)) uut (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .issueKind(issueKind),
    .issueDest(issueDest), .issueReady(issueReady), .issueTag(issueTag),
    .doneValid(doneValid), .doneTag(doneTag), .doneValue(doneValue),
    .doneMispredict(doneMispredict), .lookupTag(lookupTag), .lookupHit(lookupHit),
    .lookupValue(lookupValue), .commitRegEn(commitRegEn), .commitRegIdx(commitRegIdx),
    .commitRegData(commitRegData), .commitMemEn(commitMemEn),
    .commitMemAddr(commitMemAddr), .commitMemData(commitMemData),
    .flushIn(flushIn), .full(full), .empty(empty), .count(count)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0, bad = 0;
  bit finished = 0;

  typedef struct {
    logic [1:0]        kind;
    logic [DEST_W-1:0] dest;
    logic [DATA_W-1:0] val;
  } expItem_t;
  expItem_t sb[$];
  expItem_t cur;

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // Scoreboard monitor: every architectural write must match the oldest expected item.
  always @(negedge clk) begin
    if (rstN && (commitRegEn || commitMemEn)) begin
      chk("R10", "both write ports", 64'(commitRegEn && commitMemEn), 0);
      if (sb.size() == 0) begin
        chk("R8", "unexpected commit", 1, 0);
      end else begin
        cur = sb.pop_front();
        if (cur.kind == KIND_REG) begin
          chk("R6", "reg write enable", 64'(commitRegEn), 1);
          chk("R6", "reg index", 64'(commitRegIdx), 64'(cur.dest[REG_W-1:0]));
          chk("R6", "reg data", 64'(commitRegData), 64'(cur.val));
        end else begin
          chk("R7", "mem write enable", 64'(commitMemEn), 1);
          chk("R7", "reg enable on store", 64'(commitRegEn), 0);
          chk("R7", "mem addr", 64'(commitMemAddr), 64'(cur.dest));
          chk("R7", "mem data", 64'(commitMemData), 64'(cur.val));
        end
      end
    end
  end

  task automatic doIssue(logic [1:0] kind, logic [DEST_W-1:0] dest,
                         logic [DATA_W-1:0] val, logic [IDX_W-1:0] expTag, bit push);
    expItem_t it;
    issueValid = 1; issueKind = kind; issueDest = dest;
    #1;
    chk("R2", "issue ready", 64'(issueReady), 1);
    chk("R2", "issue tag", 64'(issueTag), 64'(expTag));
    if (push) begin
      it.kind = kind; it.dest = dest; it.val = val;
      sb.push_back(it);
    end
    @(posedge clk); #1;
    issueValid = 0;
  endtask

  task automatic doComplete(logic [IDX_W-1:0] tag, logic [DATA_W-1:0] val, logic mis);
    doneValid = 1; doneTag = tag; doneValue = val; doneMispredict = mis;
    @(posedge clk); #1;
    doneValid = 0; doneMispredict = 0;
  endtask

  task automatic waitEmpty();
    for (int i = 0; i < 40 && !empty; i++) begin
      @(posedge clk); #1;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "count after reset", 64'(count), 0);
    chk("R1", "empty after reset", 64'(empty), 1);
    chk("R1", "full after reset", 64'(full), 0);
    chk("R1", "issueReady after reset", 64'(issueReady), 1);
    rstN = 1;
    @(posedge clk); #1;

    // In-order retirement with youngest-first completion.
    doIssue(KIND_REG,   16'd5,     32'hA0A0, 3'd0, 1);
    doIssue(KIND_STORE, 16'h0100,  32'hB1B1, 3'd1, 1);
    doIssue(KIND_REG,   16'd7,     32'hC2C2, 3'd2, 1);
    chk("R2", "count after three", 64'(count), 3);
    doComplete(3'd2, 32'hC2C2, 0);
    lookupTag = 3'd2; #1;
    chk("R5", "lookup hit finished", 64'(lookupHit), 1);
    chk("R5", "lookup value", 64'(lookupValue), 64'(32'hC2C2));
    lookupTag = 3'd0; #1;
    chk("R5", "lookup miss unfinished", 64'(lookupHit), 0);
    chk("R4", "no commit for young ready", 64'(commitRegEn || commitMemEn), 0);
    doComplete(3'd1, 32'hB1B1, 0);
    chk("R4", "still no commit", 64'(commitRegEn || commitMemEn), 0);
    doComplete(3'd0, 32'hA0A0, 0);
    waitEmpty();
    chk("R6", "drained count", 64'(count), 0);
    chk("R6", "scoreboard drained", 64'(sb.size()), 0);

    // Fill across the wrap, then overflow attempt.
    for (int i = 0; i < DEPTH; i++)
      doIssue(KIND_REG, DEST_W'(8 + i), DATA_W'(32'h100 + i), IDX_W'(3 + i), 1);
    chk("R3", "full flag", 64'(full), 1);
    chk("R3", "issueReady when full", 64'(issueReady), 0);
    issueValid = 1; issueKind = KIND_REG; issueDest = 16'd30;
    @(posedge clk); #1;
    issueValid = 0;
    chk("R3", "count after overflow try", 64'(count), 8);
    for (int i = DEPTH - 1; i >= 0; i--)
      doComplete(IDX_W'(3 + i), DATA_W'(32'h100 + i), 0);
    waitEmpty();
    chk("R3", "drained after fill", 64'(sb.size()), 0);

    // Mispredicted branch discards finished younger slots.
    doIssue(KIND_REG,    16'd1,     32'h1111, 3'd3, 1);
    doIssue(KIND_BRANCH, 16'd0,     32'h0,    3'd4, 0);
    doIssue(KIND_REG,    16'd2,     32'h2222, 3'd5, 0);
    doIssue(KIND_STORE,  16'h0200,  32'h3333, 3'd6, 0);
    doComplete(3'd5, 32'h2222, 0);
    doComplete(3'd6, 32'h3333, 0);
    doComplete(3'd4, 32'h0, 1);
    chk("R4", "count before head done", 64'(count), 4);
    doComplete(3'd3, 32'h1111, 0);
    @(posedge clk); #1;
    chk("R8", "branch writes nothing", 64'(commitRegEn || commitMemEn), 0);
    chk("R8", "no issue during discard", 64'(issueReady), 0);
    @(posedge clk); #1;
    chk("R8", "count after mispredict", 64'(count), 0);
    chk("R8", "empty after mispredict", 64'(empty), 1);
    lookupTag = 3'd5; #1;
    chk("R8", "discarded slot lookup", 64'(lookupHit), 0);
    repeat (2) @(posedge clk);
    #1;
    chk("R8", "no late younger commit", 64'(sb.size()), 0);

    // Flush with a simultaneous issue.
    doIssue(KIND_REG, 16'd3, 32'h4444, 3'd5, 0);
    doIssue(KIND_REG, 16'd4, 32'h5555, 3'd6, 0);
    flushIn = 1; issueValid = 1; issueKind = KIND_REG; issueDest = 16'd9;
    @(posedge clk); #1;
    flushIn = 0; issueValid = 0;
    chk("R9", "count after flush", 64'(count), 0);
    chk("R9", "empty after flush", 64'(empty), 1);

    // Issue at the restored tail, then issue together with a retirement.
    doIssue(KIND_REG, 16'd6, 32'h6666, 3'd5, 1);
    doComplete(3'd5, 32'h6666, 0);
    chk("R11", "head commit visible", 64'(commitRegEn), 1);
    doIssue(KIND_STORE, 16'h0300, 32'h7777, 3'd6, 1);
    chk("R11", "count kept", 64'(count), 1);
    doComplete(3'd6, 32'h7777, 0);
    waitEmpty();
    chk("R7", "final scoreboard", 64'(sb.size()), 0);
    chk("R7", "final empty", 64'(empty), 1);

    repeat (2) @(posedge clk);
    finish();
  end

endmodule